// File: doc/BRIEF.md
# Programmable Timer/Counter Channel

A single 16-bit timing channel that either measures time or counts events. In the two timer modes it advances once per prescaled tick of the system clock. In the two counter modes it advances on a chosen edge of an external event input. A mode can be free-running, which wraps through the full counter range, or periodic, which reloads from a programmable value. The counting direction comes from a control bit or from an external direction pin. Each terminal count sets a sticky pending flag, which drives an interrupt line, and updates a timer output that either toggles or emits a one-clock pulse.

Software reaches the channel through a small word-addressed register port with four registers: control, prescaler, reload and status. Writing the reload register also presets the counter. The running count is brought out on its own port so that surrounding logic can use it.

Top module: `tmr_channel`

## Requirements
- R1: After reset every register reads zero, and the count, the interrupt and the timer output are 0. The registers sit at byte addresses 0x0 (control), 0x4 (prescaler), 0x8 (reload) and 0xC (status). Any other address reads zero and ignores writes.
- R2: Control bits 15:12, 7 and 3 are reserved. Writing 0xFFFF to the control register reads back as 0x0F77.
- R3: In timer modes (control bits 11:10 = 00 free, 01 periodic), one count event happens every prescaler+1 clocks while the run bit (control bit 0) is 1.
- R4: In periodic mode with the down direction, an event at count 0 is a terminal count and loads the reload value. A down-counting periodic channel preset to R therefore signals every (R+1) events.
- R5: In periodic mode with the up direction, an event at count = reload is a terminal count and returns the count to 0. Writing the reload register while the direction is up presets the count to 0; while it is down, it presets the count to the written value.
- R6: In free-running modes, down counting wraps from 0 to 0xFFFF and up counting wraps from 0xFFFF to 0. Each wrap is a terminal count.
- R7: In counter modes (bits 11:10 = 10 free, 11 periodic), control bits 9:8 select the counted edge of the external input: 00 rising, 01 falling, 10 both. With 11 nothing is counted.
- R8: With control bit 5 at 0, control bit 4 sets the direction (1 up, 0 down). With bit 5 at 1, the external direction pin sets it (1 up).
- R9: A terminal count sets the pending flag (status bit 0). Writing 1 to that bit clears it, and writing 0 leaves it alone. The interrupt output equals pending AND interrupt enable (bit 1) AND run (bit 0).
- R10: With control bit 6 at 0, the output state flips at each terminal count.
- R11: With control bit 6 at 1, the output is high for exactly the one clock that follows each terminal count.
- R12: The timer output is driven only while both output enable (bit 2) and run are 1. Otherwise it is 0.
- R13: While run is 0, the count does not change, except through a reload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| ext_cnt_i | input | 1 | External event input (asynchronous) |
| ext_dir_i | input | 1 | External direction pin, 1 = up (asynchronous) |
| cnt_o | output | 16 | Current count |
| irq_o | output | 1 | Interrupt request |
| tmr_out_o | output | 1 | Timer output |

## Verification
The bench builds the channel with a 16-bit counter and an 8-bit prescaler. At this width the whole free-running up wrap of 65536 events at prescale 0 fits in one run. It sweeps prescaler values 0 to 3 against reload values 1 to 4 in both periodic directions, and checks each terminal-count interval against (R+1)(P+1). All four edge codes, both direction sources and both output forms are driven with pulse trains whose expected counts come from simple arithmetic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        MODE_FREE_TMR = 2'b00,
        MODE_PER_TMR  = 2'b01,
        MODE_FREE_CNT = 2'b10,
        MODE_PER_CNT  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_e;

    typedef struct packed {
        logic [3:0] rsv_hi;
        mode_e      mode;
        edge_e      edge_sel;
        logic       rsv7;
        logic       pulse_form;
        logic       dir_from_pin;
        logic       dir_up;
        logic       rsv3;
        logic       out_en;
        logic       irq_en;
        logic       run;
    } ctrl_t;

    localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h0F77;

    localparam logic [3:0] ADR_CTRL = 4'h0;
    localparam logic [3:0] ADR_PSC  = 4'h4;
    localparam logic [3:0] ADR_RLD  = 4'h8;
    localparam logic [3:0] ADR_STAT = 4'hC;

    function automatic logic is_counter_mode(input mode_e m);
        return m[1];
    endfunction

    function automatic logic is_periodic(input mode_e m);
        return m[0];
    endfunction

    function automatic logic edge_hit(input edge_e sel, input logic rise, input logic fall);
        logic hit;
        unique case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt_q <= '0;
        else if (tick)   pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             up,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tc
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q, nxt, up_lim;
    logic             at_lim;

    assign up_lim = periodic ? reload : ALL_ONES;

    always_comb begin
        if (up) begin
            at_lim = (cnt_q == up_lim);
            nxt    = at_lim ? '0 : cnt_q + 1'b1;
        end else begin
            at_lim = (cnt_q == '0);
            nxt    = at_lim ? up_lim : cnt_q - 1'b1;
        end
    end

    assign tc  = evt && at_lim && !load;
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (evt)  cnt_q <= nxt;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_cnt_i,
    input  logic              ext_dir_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o,
    output logic              tmr_out_o
);
    ctrl_t            ctrl_q;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] rld_q;
    logic             pend_q, tog_q, pls_q;

    logic wr_ctrl, wr_psc, wr_rld, wr_stat;
    assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_psc  = reg_wr && (reg_addr == ADR_PSC);
    assign wr_rld  = reg_wr && (reg_addr == ADR_RLD);
    assign wr_stat = reg_wr && (reg_addr == ADR_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            rld_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata & CTRL_WMASK);
            if (wr_psc)  psc_q  <= reg_wdata[PSC_W-1:0];
            if (wr_rld)  rld_q  <= reg_wdata[CNT_W-1:0];
        end
    end

    // external inputs: synchronise, then detect edges on the event line
    logic [1:0] sync_q;
    logic       evin_prev_q, ev_rise, ev_fall;

    tmr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_dir_i, ext_cnt_i}),
        .q   (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) evin_prev_q <= 1'b0;
        else     evin_prev_q <= sync_q[0];
    end

    assign ev_rise = sync_q[0] && !evin_prev_q;
    assign ev_fall = !sync_q[0] && evin_prev_q;

    // event selection
    logic run_w, ie_w, oe_w, up_w, per_w, cnt_mode, tick, evt_w, tc;

    assign run_w    = ctrl_q.run;
    assign ie_w     = ctrl_q.irq_en;
    assign oe_w     = ctrl_q.out_en;
    assign cnt_mode = is_counter_mode(ctrl_q.mode);
    assign per_w    = is_periodic(ctrl_q.mode);
    assign up_w     = ctrl_q.dir_from_pin ? sync_q[1] : ctrl_q.dir_up;

    tmr_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w && !cnt_mode),
        .div  (psc_q),
        .tick (tick)
    );

    assign evt_w = run_w && (cnt_mode ? edge_hit(ctrl_q.edge_sel, ev_rise, ev_fall) : tick);

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .up       (up_w),
        .periodic (per_w),
        .reload   (rld_q),
        .load     (wr_rld),
        .load_val (up_w ? '0 : reg_wdata[CNT_W-1:0]),
        .cnt      (cnt_o),
        .tc       (tc)
    );

    // pending flag and output forms
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            tog_q  <= 1'b0;
            pls_q  <= 1'b0;
        end else begin
            if (tc)                        pend_q <= 1'b1;
            else if (wr_stat && reg_wdata[0]) pend_q <= 1'b0;
            if (tc) tog_q <= !tog_q;
            pls_q <= tc;
        end
    end

    assign irq_o     = pend_q && ie_w && run_w;
    assign tmr_out_o = run_w && oe_w && (ctrl_q.pulse_form ? pls_q : tog_q);

    always_comb begin
        unique case (reg_addr)
            ADR_CTRL: reg_rdata = DATA_W'(ctrl_q);
            ADR_PSC:  reg_rdata = DATA_W'(psc_q);
            ADR_RLD:  reg_rdata = DATA_W'(rld_q);
            ADR_STAT: reg_rdata = DATA_W'(pend_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic [15:0]      reg_wdata,
    input logic [CNT_W-1:0] cnt_o,
    input logic             irq_o,
    input logic             tmr_out_o,
    input logic             run_w,
    input logic             ie_w,
    input logic             oe_w,
    input logic             up_w,
    input logic             per_w,
    input logic             evt_w,
    input logic             pend_q,
    input logic [CNT_W-1:0] rld_q
);
    logic ld_wr, clr_wr;
    assign ld_wr  = reg_wr && (reg_addr == 4'h8);
    assign clr_wr = reg_wr && (reg_addr == 4'hC) && reg_wdata[0];

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (run_w && ie_w && pend_q));

    a_r12_out_gate: assert property (@(posedge clk) disable iff (rst)
        tmr_out_o |-> (run_w && oe_w));

    a_r13_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_w && !ld_wr) |=> $stable(cnt_o));

    a_r9_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_wr) |=> pend_q);

    a_r4_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (evt_w && !up_w && per_w && cnt_o == '0 && !ld_wr) |=> (cnt_o == $past(rld_q)));

    a_r6_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (evt_w && !up_w && !per_w && cnt_o == '0 && !ld_wr) |=> (cnt_o == '1));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_o     (cnt_o),
    .irq_o     (irq_o),
    .tmr_out_o (tmr_out_o),
    .run_w     (run_w),
    .ie_w      (ie_w),
    .oe_w      (oe_w),
    .up_w      (up_w),
    .per_w     (per_w),
    .evt_w     (evt_w),
    .pend_q    (pend_q),
    .rld_q     (rld_q)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
    localparam int TE = 1, IE = 2, OE = 4, UD = 16, UDS = 32, OM = 64;
    localparam int M_PT = 1 << 10, M_FC = 2 << 10, M_PC = 3 << 10;

    logic        clk = 0, rst = 1;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        ext_cnt_i = 0, ext_dir_i = 0;
    logic [15:0] cnt_o;
    logic        irq_o, tmr_out_o;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    tmr_channel #(.CNT_W(16), .PSC_W(8), .SYNC_STAGES(2)) i_tmr_channel (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt_i(ext_cnt_i),
        .ext_dir_i(ext_dir_i), .cnt_o(cnt_o), .irq_o(irq_o), .tmr_out_o(tmr_out_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d[15:0];
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        while (!irq_o && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (4) @(negedge clk);
            ext_cnt_i = 1;
            repeat (4) @(negedge clk);
            ext_cnt_i = 0;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic stop_clear();
        wr(4'h0, 0);
        wr(4'hC, 1);
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int n, hi, tg;
        logic prev;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, d); chk("R1 ctrl", d, 0);
        rd(4'h4, d); chk("R1 psc", d, 0);
        rd(4'h8, d); chk("R1 reload", d, 0);
        rd(4'hC, d); chk("R1 status", d, 0);
        chk("R1 cnt", cnt_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 out", tmr_out_o, 0);
        wr(4'h4, 8'h5A); rd(4'h4, d); chk("R1 psc readback", d, 16'h5A);
        wr(4'h2, 16'hFFFF); rd(4'h2, d); chk("R1 unmapped", d, 0);
        rd(4'h4, d); chk("R1 unmapped write ignored", d, 16'h5A);

        // R2 reserved bits
        wr(4'h0, 16'hFFFF); rd(4'h0, d); chk("R2 reserved", d, 16'h0F77);
        wr(4'h0, 0);
        chk("R13 stopped cnt after ctrl fuzz", cnt_o, 0);

        // R3/R4 periodic down sweep
        for (int p = 0; p < 4; p++) begin
            for (int r = 1; r <= 4; r++) begin
                stop_clear();
                wr(4'h4, p);
                wr(4'h8, r);
                wr(4'h0, M_PT | IE | TE);
                wait_irq(200, n);
                chk($sformatf("R3 R4 down period p=%0d r=%0d", p, r), n, (r + 1) * (p + 1));
                chk("R4 reloaded value", cnt_o, r);
            end
        end

        // R5 periodic up sweep
        for (int p = 0; p < 4; p++) begin
            for (int r = 1; r <= 4; r++) begin
                stop_clear();
                wr(4'h0, UD);
                wr(4'h4, p);
                wr(4'h8, r);
                chk("R5 up preset zero", cnt_o, 0);
                wr(4'h0, M_PT | UD | IE | TE);
                wait_irq(200, n);
                chk($sformatf("R5 up period p=%0d r=%0d", p, r), n, (r + 1) * (p + 1));
                chk("R5 back to zero", cnt_o, 0);
            end
        end

        // R6 free running wraps
        stop_clear();
        wr(4'h4, 0);
        wr(4'h8, 2);
        wr(4'h0, IE | TE);
        wait_irq(100, n);
        chk("R6 free down cycles", n, 3);
        chk("R6 free down wrap", cnt_o, 16'hFFFF);
        stop_clear();
        wr(4'h0, UD);
        wr(4'h8, 7);
        wr(4'h0, UD | IE | TE);
        wait_irq(70000, n);
        chk("R6 free up cycles", n, 65536);
        chk("R6 free up wrap", cnt_o, 0);

        // R7 edge selection in free counter mode
        for (int e = 0; e < 4; e++) begin
            stop_clear();
            wr(4'h0, M_FC | (e << 8));
            wr(4'h8, 20);
            wr(4'h0, M_FC | (e << 8) | TE);
            pulses(3);
            chk($sformatf("R7 edge code %0d", e), cnt_o, 20 - 3 * ((e == 2) ? 2 : (e == 3) ? 0 : 1));
        end

        // R7 periodic counter reload
        stop_clear();
        wr(4'h8, 2);
        wr(4'h0, M_PC | IE | TE);
        pulses(3);
        chk("R7 periodic counter pending", irq_o, 1);
        chk("R7 periodic counter reloaded", cnt_o, 2);

        // R8 direction source
        stop_clear();
        ext_dir_i = 1;
        wr(4'h0, M_FC | UDS);
        repeat (4) @(negedge clk);
        wr(4'h8, 20);
        chk("R8 pin up preset", cnt_o, 0);
        wr(4'h0, M_FC | UDS | TE);
        pulses(3);
        chk("R8 pin up count", cnt_o, 3);
        ext_dir_i = 0;
        repeat (4) @(negedge clk);
        pulses(2);
        chk("R8 pin down count", cnt_o, 1);
        stop_clear();
        ext_dir_i = 1;
        wr(4'h0, M_FC);
        repeat (4) @(negedge clk);
        wr(4'h8, 20);
        wr(4'h0, M_FC | TE);
        pulses(2);
        chk("R8 bit down ignores pin", cnt_o, 18);
        ext_dir_i = 0;

        // R9/R12 gating
        stop_clear();
        wr(4'h8, 1);
        wr(4'h0, M_PT | TE);
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            hi += tmr_out_o;
        end
        chk("R12 out disabled", hi, 0);
        chk("R9 irq masked", irq_o, 0);
        rd(4'hC, d); chk("R9 pending set", d, 1);
        wr(4'h0, M_PT | IE | TE);
        chk("R9 irq enabled", irq_o, 1);
        wr(4'h0, M_PT | IE);
        chk("R9 irq needs run", irq_o, 0);
        d = cnt_o;
        repeat (10) @(negedge clk);
        chk("R13 count held", cnt_o, d);
        wr(4'hC, 0); rd(4'hC, d); chk("R9 write zero keeps", d, 1);
        wr(4'hC, 1); rd(4'hC, d); chk("R9 write one clears", d, 0);

        // R10 toggle
        stop_clear();
        wr(4'h8, 1);
        wr(4'h0, M_PT | OE | TE);
        repeat (2) @(negedge clk);
        chk("R10 toggle first", tmr_out_o, 1);
        repeat (2) @(negedge clk);
        chk("R10 toggle second", tmr_out_o, 0);
        stop_clear();
        wr(4'h8, 3);
        wr(4'h0, M_PT | OE | TE);
        tg = 0; prev = tmr_out_o;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tmr_out_o != prev) tg++;
            prev = tmr_out_o;
        end
        chk("R10 toggle transitions", tg, 10);

        // R11 pulse
        stop_clear();
        wr(4'h8, 3);
        wr(4'h0, M_PT | OM | OE | TE);
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            hi += tmr_out_o;
        end
        chk("R11 pulse high cycles", hi, 10);
        wr(4'h0, M_PT | OM | OE);
        chk("R12 out needs run", tmr_out_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule